// File: doc/BRIEF.md
# Two-Wire Configuration Register Bank

This block is a two-wire (I2C-compatible) bus target that holds the configuration of a radio tuner. It samples SCL and SDA on a fast system clock through synchronizer stages and decodes START and STOP conditions from them. It accepts a 7-bit device address, and one input pin moves that address to a second value so that two tuners can share one bus. It keeps twelve writable configuration registers, each with a reset default, and two read-only status registers that reflect live status inputs.

A write transfer sets a register pointer and then fills successive registers. A read transfer sets the pointer with a write and then uses a repeated START to fetch successive registers. A write to the fractional-divider low byte (register 4) emits a one-cycle pulse that starts the VCO band search. The status byte at 0x0C carries a sticky power-up flag. Reset sets this flag, and it is cleared only by a STOP that follows a transfer of that status byte to the bus master.

The bus side drives a single pull-low enable, which models an open-drain pad. All configuration register contents are presented on one flat output vector.

Top module: `i2c_cfg_bank`

## Requirements
- R1: With `addr_sel`=0 the block ACKs device bytes 0xC0 (write) and 0xC1 (read). With `addr_sel`=1 it ACKs 0xC2 and 0xC3 instead. Any other device byte gets a NACK, and the block ignores the bus until the next START.
- R2: A STOP at any point returns the block to idle and releases SDA. A START at any point restarts device-address reception. The SDA pull-low enable only rises or falls in the cycle after an SCL falling edge, a START or a STOP.
- R3: In a write transfer, the byte after the device byte loads the register pointer. Each following data byte is stored MSB first at the pointer, and the pointer then advances. The block ACKs every byte.
- R4: A write of the pointer, a repeated START and the read device byte make the block return successive registers, MSB first, for as long as the master ACKs. After a master NACK it releases SDA.
- R5: The reset values of registers 0x00 to 0x0B are 0x80, 0x23, 0x02, 0xF6, 0x84, 0x01, 0xC0, 0xC9, 0x4B, 0x00, 0x00 and 0x08.
- R6: A write to register 0x04 makes `vco_search_start` high for exactly one clock. Writes to any other register leave it low.
- R7: Status register 0x0C reads as {power flag, stat_flags[2:0], 4'b0000}. Status register 0x0D reads as `stat_band[7:0]`, with the band number in bits 7:3 and the converter code in bits 2:0.
- R8: Reset sets the power flag. The flag clears at the first STOP after a byte of register 0x0C has been sent to the master. Reads of other registers do not clear it, and nothing sets it again except reset.
- R9: Data bytes written to 0x0C or 0x0D are ACKed, change no register and still advance the pointer.
- R10: The pointer wraps from 0x0D to 0x00, both in burst writes and in burst reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | Selects the alternate device address |
| stat_flags | input | 3 | Search-success, search-idle and lock flags, shown at 0x0C bits 6:4 |
| stat_band | input | 8 | Band and converter readback shown at 0x0D |
| sda_pull | output | 1 | Pulls SDA low when high |
| cfg_regs | output | 96 | Register n occupies bits 8n+7:8n |
| vco_search_start | output | 1 | One-cycle pulse after a write to register 0x04 |

## Verification
The bench exercises the function with single-register writes, multi-byte bursts that cross the read-only window and wrap to 0x00, and repeated-START reads that end on either an ACK or a NACK. Together these separate correct pointer advance from a pointer that saturates or skips the status addresses. It sends device bytes that belong to the other strap setting, to show that matching depends on `addr_sel` and that a NACKed transfer writes nothing. Status reads are placed before and after reads of other registers, so that a flag cleared too early or never cleared shows up. A reference copy of the registers and of the trigger count is compared with the outputs on every clock.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
   localparam int unsigned REG_W      = 8;
   localparam int unsigned NUM_CFG    = 12;
   localparam int unsigned STAT0_ADDR = 12;
   localparam int unsigned STAT1_ADDR = 13;
   localparam int unsigned LAST_ADDR  = STAT1_ADDR;
   localparam int unsigned CFG_BITS   = REG_W * NUM_CFG;

   typedef enum logic [2:0] {
      LK_IDLE, LK_RECV, LK_RACK, LK_SEND, LK_SACK
   } link_st_e;

   typedef enum logic [1:0] {
      BY_DEV, BY_PTR, BY_DATA
   } byte_kind_e;

   function automatic logic [REG_W-1:0] cfg_default(input int unsigned idx);
      case (idx)
         0:       return 8'h80;
         1:       return 8'h23;
         2:       return 8'h02;
         3:       return 8'hF6;
         4:       return 8'h84;
         5:       return 8'h01;
         6:       return 8'hC0;
         7:       return 8'hC9;
         8:       return 8'h4B;
         11:      return 8'h08;
         default: return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/i2c_cfg_sync.sv
module i2c_cfg_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_cfg_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic scl_q, sda_q, scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
   assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_cfg_link.sv
module i2c_cfg_link
   import i2c_cfg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h60,
   parameter bit         PTR_WRAP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr_sel,
   input  logic             sda_s,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             bus_start,
   input  logic             bus_stop,
   input  logic [REG_W-1:0] rd_data,
   output logic [REG_W-1:0] ptr_q,
   output logic             sda_pull,
   output logic             wr_en,
   output logic [REG_W-1:0] wr_addr,
   output logic [REG_W-1:0] wr_data,
   output logic             rd_en,
   output logic [REG_W-1:0] rd_addr
);
   generate
      if (DEV_ADDR[0] != 1'b0) begin : g_bad_addr
         $error("i2c_cfg_link: DEV_ADDR bit 0 is taken by addr_sel");
      end
   endgenerate

   link_st_e         st_q;
   byte_kind_e       kind_q;
   logic [3:0]       cnt_q;
   logic [REG_W-1:0] sh_q, tx_q, ptr_nxt;
   logic             rw_q, nack_q;
   logic [6:0]       my_addr;

   assign my_addr = DEV_ADDR | {6'd0, addr_sel};

   generate
      if (PTR_WRAP) begin : g_wrap
         assign ptr_nxt = (ptr_q >= REG_W'(LAST_ADDR)) ? '0 : ptr_q + 1'b1;
      end else begin : g_sat
         assign ptr_nxt = (ptr_q >= REG_W'(LAST_ADDR)) ? ptr_q : ptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= LK_IDLE;
         kind_q   <= BY_DEV;
         cnt_q    <= '0;
         sh_q     <= '0;
         tx_q     <= '0;
         rw_q     <= 1'b0;
         nack_q   <= 1'b0;
         ptr_q    <= '0;
         sda_pull <= 1'b0;
         wr_en    <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
         rd_en    <= 1'b0;
         rd_addr  <= '0;
      end else begin
         wr_en <= 1'b0;
         rd_en <= 1'b0;
         if (bus_stop) begin
            st_q     <= LK_IDLE;
            sda_pull <= 1'b0;
         end else if (bus_start) begin
            st_q     <= LK_RECV;
            kind_q   <= BY_DEV;
            cnt_q    <= '0;
            sda_pull <= 1'b0;
         end else begin
            case (st_q)
               LK_RECV: begin
                  if (scl_rise) begin
                     sh_q  <= {sh_q[REG_W-2:0], sda_s};
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall && cnt_q == 4'd8) begin
                     cnt_q <= '0;
                     case (kind_q)
                        BY_DEV: begin
                           if (sh_q[7:1] == my_addr) begin
                              rw_q     <= sh_q[0];
                              sda_pull <= 1'b1;
                              st_q     <= LK_RACK;
                           end else begin
                              st_q <= LK_IDLE;
                           end
                        end
                        BY_PTR: begin
                           ptr_q    <= sh_q;
                           sda_pull <= 1'b1;
                           st_q     <= LK_RACK;
                        end
                        default: begin
                           wr_en    <= 1'b1;
                           wr_addr  <= ptr_q;
                           wr_data  <= sh_q;
                           ptr_q    <= ptr_nxt;
                           sda_pull <= 1'b1;
                           st_q     <= LK_RACK;
                        end
                     endcase
                  end
               end
               LK_RACK: begin
                  if (scl_fall) begin
                     if (kind_q == BY_DEV && rw_q) begin
                        tx_q     <= rd_data;
                        sda_pull <= ~rd_data[REG_W-1];
                        rd_en    <= 1'b1;
                        rd_addr  <= ptr_q;
                        ptr_q    <= ptr_nxt;
                        cnt_q    <= 4'd1;
                        st_q     <= LK_SEND;
                     end else begin
                        sda_pull <= 1'b0;
                        kind_q   <= (kind_q == BY_DEV) ? BY_PTR : BY_DATA;
                        st_q     <= LK_RECV;
                     end
                  end
               end
               LK_SEND: begin
                  if (scl_fall) begin
                     if (cnt_q == 4'd8) begin
                        sda_pull <= 1'b0;
                        st_q     <= LK_SACK;
                     end else begin
                        tx_q     <= {tx_q[REG_W-2:0], 1'b0};
                        sda_pull <= ~tx_q[REG_W-2];
                        cnt_q    <= cnt_q + 1'b1;
                     end
                  end
               end
               LK_SACK: begin
                  if (scl_rise) begin
                     nack_q <= sda_s;
                  end else if (scl_fall) begin
                     if (!nack_q) begin
                        tx_q     <= rd_data;
                        sda_pull <= ~rd_data[REG_W-1];
                        rd_en    <= 1'b1;
                        rd_addr  <= ptr_q;
                        ptr_q    <= ptr_nxt;
                        cnt_q    <= 4'd1;
                        st_q     <= LK_SEND;
                     end else begin
                        st_q <= LK_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R2: the pull-low enable moves only while SCL is low or on a bus condition
   a_r2_pull_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> $past(scl_fall));
   a_r2_pull_fall_framed: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_pull) |-> $past(scl_fall || bus_stop || bus_start));
   a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stop |=> !sda_pull);
   // R3: a register store follows the falling edge that closes a data byte
   a_r3_store_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(scl_fall));
endmodule

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs
   import i2c_cfg_pkg::*;
#(
   parameter int unsigned TRIG_REG = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [REG_W-1:0]    wr_addr,
   input  logic [REG_W-1:0]    wr_data,
   input  logic                rd_en,
   input  logic [REG_W-1:0]    rd_addr,
   input  logic                bus_stop,
   input  logic [REG_W-1:0]    ptr_q,
   input  logic [2:0]          stat_flags,
   input  logic [REG_W-1:0]    stat_band,
   output logic [REG_W-1:0]    rd_data,
   output logic [CFG_BITS-1:0] cfg_flat,
   output logic                trig
);
   generate
      if (TRIG_REG >= NUM_CFG) begin : g_bad_trig
         $error("i2c_cfg_regs: TRIG_REG must be a writable register");
      end
   endgenerate

   logic [REG_W-1:0] cfg_q [NUM_CFG];
   logic             por_q, por_arm_q;

   for (genvar i = 0; i < NUM_CFG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 cfg_q[i] <= cfg_default(i);
         else if (wr_en && wr_addr == REG_W'(i))     cfg_q[i] <= wr_data;
      end
      assign cfg_flat[i*REG_W +: REG_W] = cfg_q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         por_q     <= 1'b1;
         por_arm_q <= 1'b0;
         trig      <= 1'b0;
      end else begin
         trig <= wr_en && (wr_addr == REG_W'(TRIG_REG));
         if (bus_stop) begin
            if (por_arm_q) por_q <= 1'b0;
            por_arm_q <= 1'b0;
         end else if (rd_en && rd_addr == REG_W'(STAT0_ADDR)) begin
            por_arm_q <= 1'b1;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_CFG; i++)
         if (ptr_q == REG_W'(i)) rd_data = cfg_q[i];
      if (ptr_q == REG_W'(STAT0_ADDR)) rd_data = {por_q, stat_flags, 4'b0000};
      if (ptr_q == REG_W'(STAT1_ADDR)) rd_data = stat_band;
   end

   // R6: the search trigger never lasts longer than one clock
   a_r6_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> !trig);
   // R8: the power flag never comes back without reset, and falls only on a STOP
   a_r8_por_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !por_q |=> !por_q);
   a_r8_por_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(por_q) |-> $past(bus_stop));
   // R9: registers change only on a store, and never on a store to a status address
   a_r9_hold_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg_flat));
   a_r9_status_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr >= REG_W'(NUM_CFG)) |=> $stable(cfg_flat));
endmodule

// File: rtl/i2c_cfg_bank.sv
module i2c_cfg_bank
   import i2c_cfg_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR    = 7'h60,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          PTR_WRAP    = 1'b1,
   parameter int unsigned TRIG_REG    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_i,
   input  logic                sda_i,
   input  logic                addr_sel,
   input  logic [2:0]          stat_flags,
   input  logic [7:0]          stat_band,
   output logic                sda_pull,
   output logic [CFG_BITS-1:0] cfg_regs,
   output logic                vco_search_start
);
   logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;
   logic wr_en, rd_en;
   logic [REG_W-1:0] wr_addr, wr_data, rd_addr, rd_data, ptr_q;

   i2c_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .bus_start(bus_start), .bus_stop(bus_stop)
   );

   i2c_cfg_link #(.DEV_ADDR(DEV_ADDR), .PTR_WRAP(PTR_WRAP)) u_link (
      .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .bus_start(bus_start), .bus_stop(bus_stop), .rd_data(rd_data),
      .ptr_q(ptr_q), .sda_pull(sda_pull), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr)
   );

   i2c_cfg_regs #(.TRIG_REG(TRIG_REG)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
      .bus_stop(bus_stop), .ptr_q(ptr_q), .stat_flags(stat_flags),
      .stat_band(stat_band), .rd_data(rd_data), .cfg_flat(cfg_regs),
      .trig(vco_search_start)
   );
endmodule

// File: tb/tb_i2c_cfg_bank.sv
`timescale 1ns/1ps
module tb_i2c_cfg_bank;
   localparam int H = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        addr_sel = 1'b0;
   logic [2:0]  stat_flags = 3'b101;
   logic [7:0]  stat_band = 8'h6A;
   logic        sda_pull;
   logic [95:0] cfg_regs;
   logic        vco_search_start;
   logic        sda_w;

   int  n_chk = 0;
   int  n_fail = 0;
   int  trig_seen = 0;
   int  trig_exp = 0;
   bit  hold = 1'b0;
   bit  cmp_on = 1'b0;
   logic [7:0] exp_q [12];

   always #4 clk = ~clk;
   assign sda_w = sda_m & ~sda_pull;

   i2c_cfg_bank dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_w),
      .addr_sel(addr_sel), .stat_flags(stat_flags), .stat_band(stat_band),
      .sda_pull(sda_pull), .cfg_regs(cfg_regs),
      .vco_search_start(vco_search_start)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [127:0] act, input logic [127:0] ex);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, ex);
      end
   endtask

   function automatic logic [95:0] exp_flat();
      logic [95:0] v;
      for (int i = 0; i < 12; i++) v[i*8 +: 8] = exp_q[i];
      return v;
   endfunction

   // R5 R3 R6: reference registers and trigger count against outputs each clock
   always @(negedge clk) begin
      if (vco_search_start) trig_seen++;
      if (cmp_on && !hold) begin
         chk(cfg_regs == exp_flat(), "R3/R5 register image", cfg_regs, exp_flat());
         chk(trig_seen == trig_exp, "R6 trigger count", trig_seen, trig_exp);
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_clk(H);
      scl_m = 1'b1; wait_clk(H);
      sda_m = 1'b0; wait_clk(H);
      scl_m = 1'b0; wait_clk(H);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_clk(H);
      scl_m = 1'b1; wait_clk(H);
      sda_m = 1'b1; wait_clk(H);
   endtask

   task automatic tx_byte(input logic [7:0] b, input bit is_wr, input int idx,
                          output bit acked);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i];
         if (i == 0 && is_wr) hold = 1'b1;
         wait_clk(H); scl_m = 1'b1; wait_clk(H); scl_m = 1'b0;
      end
      sda_m = 1'b1;
      wait_clk(H); scl_m = 1'b1; wait_clk(H/2);
      acked = !sda_w;
      wait_clk(H/2);
      if (is_wr) begin
         if (idx < 12) begin
            exp_q[idx] = b;
            if (idx == 4) trig_exp++;
         end
         hold = 1'b0;
      end
      scl_m = 1'b0;
   endtask

   task automatic rx_byte(input bit mack, output logic [7:0] b);
      sda_m = 1'b1;
      b = '0;
      for (int i = 0; i < 8; i++) begin
         wait_clk(H); scl_m = 1'b1; wait_clk(H/2);
         b = {b[6:0], sda_w};
         wait_clk(H/2); scl_m = 1'b0;
      end
      sda_m = !mack;
      wait_clk(H); scl_m = 1'b1; wait_clk(H); scl_m = 1'b0;
      wait_clk(2);
      sda_m = 1'b1;
   endtask

   task automatic open_read(input logic [7:0] dev, input logic [7:0] p, input string tag);
      bit a;
      bus_start();
      tx_byte(dev, 1'b0, 0, a);          chk(a, tag, a, 1);
      tx_byte(p, 1'b0, 0, a);            chk(a, tag, a, 1);
      bus_start();
      tx_byte(dev | 8'h01, 1'b0, 0, a);  chk(a, tag, a, 1);
   endtask

   task automatic read_one(input logic [7:0] dev, input logic [7:0] p,
                           input logic [7:0] ex, input string tag);
      logic [7:0] b;
      open_read(dev, p, tag);
      rx_byte(1'b0, b);
      chk(b == ex, tag, b, ex);
      bus_stop();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual 150000 cycles expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      bit a;
      logic [7:0] b;
      exp_q = '{8'h80, 8'h23, 8'h02, 8'hF6, 8'h84, 8'h01,
                8'hC0, 8'hC9, 8'h4B, 8'h00, 8'h00, 8'h08};
      wait_clk(10);
      rst_n = 1'b1;
      wait_clk(4);
      // R5: reset state
      chk(cfg_regs == exp_flat(), "R5 defaults", cfg_regs, exp_flat());
      chk(cfg_regs[63:56] == 8'hC9, "R5 reg7", cfg_regs[63:56], 8'hC9);
      chk(sda_pull == 1'b0, "R2 idle release", sda_pull, 0);
      cmp_on = 1'b1;

      // R1 R3: burst write to registers 0..2
      bus_start();
      tx_byte(8'hC0, 0, 0, a); chk(a, "R1 ack C0", a, 1);
      tx_byte(8'h00, 0, 0, a); chk(a, "R3 ack pointer", a, 1);
      tx_byte(8'h0E, 1, 0, a); chk(a, "R3 ack data0", a, 1);
      tx_byte(8'hD8, 1, 1, a); chk(a, "R3 ack data1", a, 1);
      tx_byte(8'hE1, 1, 2, a); chk(a, "R3 ack data2", a, 1);
      bus_stop();
      chk(sda_pull == 1'b0, "R2 release after stop", sda_pull, 0);

      // R1: foreign address ignored
      bus_start();
      tx_byte(8'hC2, 0, 0, a); chk(!a, "R1 nack C2 sel0", a, 0);
      tx_byte(8'h05, 0, 0, a); chk(!a, "R1 ignored after nack", a, 0);
      tx_byte(8'h77, 0, 0, a); chk(!a, "R1 ignored after nack", a, 0);
      bus_stop();

      // R6: register 3 gives no pulse, register 4 gives one
      bus_start();
      tx_byte(8'hC0, 0, 0, a); tx_byte(8'h03, 0, 0, a);
      tx_byte(8'h11, 1, 3, a); chk(a, "R3 ack reg3", a, 1);
      bus_stop();
      chk(trig_seen == 0, "R6 no pulse for reg3", trig_seen, 0);
      bus_start();
      tx_byte(8'hC0, 0, 0, a); tx_byte(8'h04, 0, 0, a);
      tx_byte(8'h55, 1, 4, a);
      bus_stop();
      chk(trig_seen == 1, "R6 pulse for reg4", trig_seen, 1);

      // R4: repeated-start burst read
      open_read(8'hC0, 8'h00, "R4 read setup");
      rx_byte(1'b1, b); chk(b == 8'h0E, "R4 byte0", b, 8'h0E);
      rx_byte(1'b1, b); chk(b == 8'hD8, "R4 byte1", b, 8'hD8);
      rx_byte(1'b0, b); chk(b == 8'hE1, "R4 byte2", b, 8'hE1);
      wait_clk(4);
      chk(sda_pull == 1'b0, "R4 release after nack", sda_pull, 0);
      bus_stop();

      // R7 R8: status layout and power flag
      read_one(8'hC0, 8'h0D, 8'h6A, "R7 status1");
      read_one(8'hC0, 8'h0C, 8'hD0, "R8 flag kept / R7 status0");
      read_one(8'hC0, 8'h0C, 8'h50, "R8 flag cleared");

      // R9 R10: burst crossing read-only window and wrapping
      bus_start();
      tx_byte(8'hC0, 0, 0, a); tx_byte(8'h0B, 0, 0, a);
      tx_byte(8'h3C, 1, 11, a); chk(a, "R3 ack reg11", a, 1);
      tx_byte(8'hAA, 1, 12, a); chk(a, "R9 ack write 0x0C", a, 1);
      tx_byte(8'hBB, 1, 13, a); chk(a, "R9 ack write 0x0D", a, 1);
      tx_byte(8'h9E, 1, 0, a);  chk(a, "R10 ack wrapped", a, 1);
      bus_stop();
      chk(cfg_regs[7:0] == 8'h9E, "R10 wrap write reg0", cfg_regs[7:0], 8'h9E);
      open_read(8'hC0, 8'h0C, "R9 status read setup");
      rx_byte(1'b1, b); chk(b == 8'h50, "R9 status0 unchanged", b, 8'h50);
      rx_byte(1'b0, b); chk(b == 8'h6A, "R9 status1 unchanged", b, 8'h6A);
      bus_stop();

      // R10: read wrap
      open_read(8'hC0, 8'h0D, "R10 read setup");
      rx_byte(1'b1, b); chk(b == 8'h6A, "R10 read 0x0D", b, 8'h6A);
      rx_byte(1'b0, b); chk(b == 8'h9E, "R10 read wrap reg0", b, 8'h9E);
      bus_stop();

      // R1: alternate address
      addr_sel = 1'b1;
      wait_clk(4);
      bus_start();
      tx_byte(8'hC0, 0, 0, a); chk(!a, "R1 nack C0 sel1", a, 0);
      bus_stop();
      bus_start();
      tx_byte(8'hC2, 0, 0, a); chk(a, "R1 ack C2 sel1", a, 1);
      tx_byte(8'h09, 0, 0, a);
      tx_byte(8'h0F, 1, 9, a); chk(a, "R3 ack reg9", a, 1);
      bus_stop();
      read_one(8'hC2, 8'h09, 8'h0F, "R1 read via C3");

      // R2: STOP in the middle of a transfer, then a clean transfer
      bus_start();
      tx_byte(8'hC2, 0, 0, a);
      bus_stop();
      wait_clk(4);
      chk(sda_pull == 1'b0, "R2 release mid stop", sda_pull, 0);
      bus_start();
      tx_byte(8'hC2, 0, 0, a); chk(a, "R2 restart ack", a, 1);
      tx_byte(8'h0A, 0, 0, a);
      tx_byte(8'h33, 1, 10, a); chk(a, "R2 write after restart", a, 1);
      bus_stop();
      wait_clk(20);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule